// File: doc/BRIEF.md
# DAC Load Command Sequencer

This block turns a request to load a serial eight-bit DAC into the stream of sixteen-bit device command words that a host sends to a remote board. The board turns each word into pin levels. Some bits of a command word drive the DAC's serial data, serial clock and frame-sync pins directly, and others drive the select pins of the two DACs. Each bit of the DAC's sixteen-bit control word therefore needs two command words: one raises the clock with the data bit present, and one lowers the clock so that the falling edge latches the bit. Two more words open the frame and select the target, and one word closes it. A single load is exactly thirty-five command words long.

A request names the target (DAC one, DAC two, or both), an eight-bit value and two optional control flags. The block accepts the request on a valid/ready handshake. It then presents one command word at a time on a second valid/ready handshake. The words are spaced by at least a parameterised number of idle cycles, which models the time the link needs for each command. A one-cycle done pulse marks the end of the load.

Top module: `dac_cmd_seq`

## Requirements
- R1: Every command word holds the board's wake bit at position 7. Serial data is at bit 15, serial clock at bit 14 and frame sync at bit 13. The DAC two select is at bit 11 and the DAC one select at bit 10. All other bits are zero. On `req_sel`, bit 0 selects DAC one and bit 1 selects DAC two.
- R2: The first word of a load is 0x6080: frame sync and clock high, no DAC selected.
- R3: The second word is 0x6080 with the requested select bits added, for example 0x6480 for DAC one.
- R4: Words 3 to 34 carry the sixteen serial bits, most significant first, in pairs. The first word of a pair has clock 1. The second has clock 0. Both words carry the bit on the data line, frame sync 0 and the select bits.
- R5: The serial word is laid out as follows: bit 15 is 0, bit 14 is the speed flag, bit 13 is the power flag and bit 12 is 0. Bits 11..4 hold the value, most significant first, and bits 3..0 are 0.
- R6: The last word is 0x4080, and a load contains exactly 35 words.
- R7: `done` is high for exactly one cycle, in the cycle after the handshake of the final word, and at no other time.
- R8: `req_ready` is high only while no load is in progress. A request presented during a load is ignored and does not change the words that are emitted.
- R9: After each accepted word, `cmd_valid` stays low for `GAP_CYCLES` cycles. While `cmd_valid` is high and `cmd_ready` is low, the word is held unchanged.
- R10: A synchronous reset abandons any load. After reset, `cmd_valid` and `done` are low and `req_ready` is high.
- R11: The value, select and flags are captured when the request is accepted. Later changes on those inputs have no effect on the load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_sel | input | 2 | DAC select, bit 0 DAC one, bit 1 DAC two |
| req_value | input | VALUE_W | Value to load |
| req_speed | input | 1 | Speed control flag for the serial word |
| req_power | input | 1 | Power control flag for the serial word |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Link takes the command word |
| cmd_word | output | 16 | Device command word |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The bench builds the block with `GAP_CYCLES` set to 3. This keeps each load to a few hundred cycles, so several loads fit into one run. The short gap also lets link back-pressure fall both inside and outside the idle window, which exercises the word-hold rule and the pacing counter together. With a gap this short, a new request issued right after `done` can arrive while the counter is still running. That shows that the spacing between words also holds across two loads.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int CMD_W    = 16;
    localparam int FRAME_W  = 16;
    localparam int CTRL_W   = 4;

    // command word bit positions decoded by the remote board
    localparam int BIT_DIN  = 15;
    localparam int BIT_SCLK = 14;
    localparam int BIT_FS   = 13;
    localparam int BIT_SEL2 = 11;
    localparam int BIT_SEL1 = 10;
    localparam int BIT_WAKE = 7;

    // words ahead of and after the serial bit pairs
    localparam int LEAD_WORDS = 2;
    localparam int TAIL_WORDS = 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dcs_frame_builder.sv
module dcs_frame_builder
    import dcs_pkg::*;
#(
    parameter int VALUE_W = 8
) (
    input  logic [VALUE_W-1:0] value,
    input  logic               speed,
    input  logic               power,
    output logic [FRAME_W-1:0] frame
);

    localparam int PAD_W = FRAME_W - CTRL_W - VALUE_W;

    logic [CTRL_W-1:0] ctrl;

    // control nibble: unused, speed, power, unused
    assign ctrl = {1'b0, speed, power, 1'b0};

    generate
        if (PAD_W > 0) begin : g_pad
            assign frame = {ctrl, value, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign frame = {ctrl, value};
        end
    endgenerate

endmodule

// File: rtl/dcs_word_encoder.sv
module dcs_word_encoder
    import dcs_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [FRAME_W-1:0] frame,
    input  logic [1:0]         sel,
    output logic [CMD_W-1:0]   word
);

    localparam int LAST_IDX = LEAD_WORDS + 2 * FRAME_W + TAIL_WORDS - 1;

    logic [IDX_W-1:0]   slot;
    logic [FRAME_W-1:0] shifted;

    // slot counts words inside the bit-pair region; its upper bits are the bit number
    assign slot    = idx - IDX_W'(LEAD_WORDS);
    assign shifted = frame << slot[IDX_W-1:1];

    always_comb begin
        word           = '0;
        word[BIT_WAKE] = 1'b1;
        if (idx == '0) begin
            word[BIT_FS]   = 1'b1;
            word[BIT_SCLK] = 1'b1;
        end else if (idx == IDX_W'(1)) begin
            word[BIT_FS]   = 1'b1;
            word[BIT_SCLK] = 1'b1;
            word[BIT_SEL1] = sel[0];
            word[BIT_SEL2] = sel[1];
        end else if (idx == IDX_W'(LAST_IDX)) begin
            word[BIT_SCLK] = 1'b1;
        end else begin
            word[BIT_SEL1] = sel[0];
            word[BIT_SEL2] = sel[1];
            word[BIT_SCLK] = ~slot[0];
            word[BIT_DIN]  = shifted[FRAME_W-1];
        end
    end

endmodule

// File: rtl/dcs_pacer.sv
module dcs_pacer #(
    parameter int GAP_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic ready
);

    generate
        if (GAP_CYCLES == 0) begin : g_nogap
            assign ready = 1'b1;
        end else begin : g_gap
            localparam int CNT_W = $clog2(GAP_CYCLES + 1);

            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (load) begin
                    cnt_d = CNT_W'(GAP_CYCLES);
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign ready = (cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/dac_cmd_seq.sv
module dac_cmd_seq
    import dcs_pkg::*;
#(
    parameter int GAP_CYCLES = 200,
    parameter int VALUE_W    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_sel,
    input  logic [VALUE_W-1:0] req_value,
    input  logic               req_speed,
    input  logic               req_power,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [CMD_W-1:0]   cmd_word,
    output logic               done
);

    localparam int WORD_COUNT = LEAD_WORDS + 2 * FRAME_W + TAIL_WORDS;
    localparam int LAST_IDX   = WORD_COUNT - 1;
    localparam int IDX_W      = $clog2(WORD_COUNT);

    typedef struct packed {
        seq_state_e         state;
        logic [IDX_W-1:0]   idx;
        logic [1:0]         sel;
        logic [VALUE_W-1:0] value;
        logic               speed;
        logic               power;
        logic               done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic               pace_ok;
    logic               fire;
    logic [FRAME_W-1:0] frame;

    dcs_frame_builder #(
        .VALUE_W (VALUE_W)
    ) frame_i (
        .value (seq_q.value),
        .speed (seq_q.speed),
        .power (seq_q.power),
        .frame (frame)
    );

    dcs_word_encoder #(
        .IDX_W (IDX_W)
    ) enc_i (
        .idx   (seq_q.idx),
        .frame (frame),
        .sel   (seq_q.sel),
        .word  (cmd_word)
    );

    dcs_pacer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) pace_i (
        .clk   (clk),
        .rst   (rst),
        .load  (fire),
        .ready (pace_ok)
    );

    assign req_ready = (seq_q.state == ST_IDLE);
    assign cmd_valid = (seq_q.state == ST_RUN) && pace_ok;
    assign fire      = cmd_valid && cmd_ready;
    assign done      = seq_q.done;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (seq_q.state == ST_IDLE) begin
            if (req_valid) begin
                seq_d.state = ST_RUN;
                seq_d.idx   = '0;
                seq_d.sel   = req_sel;
                seq_d.value = req_value;
                seq_d.speed = req_speed;
                seq_d.power = req_power;
            end
        end else if (fire) begin
            if (seq_q.idx == IDX_W'(LAST_IDX)) begin
                seq_d.state = ST_IDLE;
                seq_d.idx   = '0;
                seq_d.done  = 1'b1;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{state: ST_IDLE, idx: '0, sel: '0, value: '0,
                       speed: 1'b0, power: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/dcs_seq_chk.sv
module dcs_seq_chk #(
    parameter int GAP_CYCLES = 200
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [15:0] cmd_word,
    input logic        done
);

    logic [5:0] sent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q <= '0;
        end else if (req_valid && req_ready) begin
            sent_q <= '0;
        end else if (cmd_valid && cmd_ready) begin
            sent_q <= sent_q + 1'b1;
        end
    end

    // R1
    wake_always_set_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_word[7]);

    // R2
    first_word_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && sent_q == 6'd0) |-> cmd_word == 16'h6080);

    // R6
    word_count_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> sent_q < 6'd35);

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> sent_q == 6'd35);

    // R8
    busy_refuses_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready);

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));

    // R9
    gap_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        (GAP_CYCLES > 0 && cmd_valid && cmd_ready) |=> !cmd_valid);

endmodule

bind dac_cmd_seq dcs_seq_chk #(
    .GAP_CYCLES (GAP_CYCLES)
) seq_chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_word  (cmd_word),
    .done      (done)
);

// File: tb/dac_cmd_seq_tb.sv
module dac_cmd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 3;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_sel = 2'b00;
    logic [7:0]  req_value = 8'h00;
    logic        req_speed = 1'b0;
    logic        req_power = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [15:0] cmd_word;
    logic        done;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    bit started    = 1'b0;
    bit finished   = 1'b0;
    bit stall_on   = 1'b0;

    // behavioural reference state
    bit          m_busy = 1'b0;
    int          m_gap  = 0;
    bit          m_done = 1'b0;
    logic [15:0] m_q[$];
    logic [15:0] got[$];

    dac_cmd_seq #(
        .GAP_CYCLES (GAP),
        .VALUE_W    (8)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_sel   (req_sel),
        .req_value (req_value),
        .req_speed (req_speed),
        .req_power (req_power),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_word  (cmd_word),
        .done      (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic build_expected(input logic [1:0] sel, input int value,
                                  input bit spd, input bit pwr);
        int serial;
        int mask;
        serial = (int'(spd) << 14) + (int'(pwr) << 13) + (value << 4);
        mask   = (sel[0] ? 'h400 : 0) + (sel[1] ? 'h800 : 0);
        m_q.delete();
        m_q.push_back(16'h6080);
        m_q.push_back(16'(32'h6080 + mask));
        for (int b = 15; b >= 0; b--) begin
            int d;
            d = (serial >> b) & 1;
            m_q.push_back(16'((d << 15) + 'h4000 + mask + 'h80));
            m_q.push_back(16'((d << 15) + mask + 'h80));
        end
        m_q.push_back(16'h4080);
    endtask

    // reference model, advanced on the edge from bench-driven inputs only
    always @(posedge clk) begin
        cycles++;
        started <= 1'b1;
        if (rst) begin
            m_busy = 1'b0;
            m_gap  = 0;
            m_done = 1'b0;
            m_q.delete();
        end else begin
            bit was_busy;
            bit nd;
            was_busy = m_busy;
            nd = 1'b0;
            if (m_busy && m_gap == 0 && cmd_ready) begin
                void'(m_q.pop_front());
                m_gap = GAP;
                if (m_q.size() == 0) begin
                    m_busy = 1'b0;
                    nd = 1'b1;
                end
            end else if (m_gap > 0) begin
                m_gap--;
            end
            if (!was_busy && req_valid) begin
                build_expected(req_sel, int'(req_value), req_speed, req_power);
                m_busy = 1'b1;
            end
            m_done = nd;
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            bit ev;
            ev = m_busy && m_gap == 0;
            check(req_ready === !m_busy, "R8 req_ready", int'(req_ready), int'(!m_busy));
            check(cmd_valid === ev, "R9 cmd_valid", int'(cmd_valid), int'(ev));
            check(done === m_done, "R7 done", int'(done), int'(m_done));
            if (ev && cmd_valid === 1'b1) begin
                int k;
                string tag;
                k = 35 - m_q.size();
                if (k == 0) tag = "R2 word";
                else if (k == 1) tag = "R3 word";
                else if (k == 34) tag = "R6 word";
                else tag = "R4/R5/R11 word";
                check(cmd_word === m_q[0], tag, int'(cmd_word), int'(m_q[0]));
            end
            if (cmd_valid === 1'b1 && cmd_ready) got.push_back(cmd_word);
        end
    end

    // link back-pressure pattern
    always @(posedge clk) begin
        #1 cmd_ready = stall_on ? ((cycles % 3) != 1) : 1'b1;
    end

    task automatic wait_idle();
        while (m_busy) @(posedge clk);
        #1;
    endtask

    task automatic start_load(input logic [1:0] sel, input logic [7:0] val,
                              input bit spd, input bit pwr);
        wait_idle();
        got.delete();
        req_valid = 1'b1;
        req_sel   = sel;
        req_value = val;
        req_speed = spd;
        req_power = pwr;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (done !== 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: state after reset
        check(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0,
              "R10 reset state", int'({req_ready, cmd_valid, done}), 'b100);

        // DAC one, value 246, link always ready
        start_load(2'b01, 8'd246, 1'b0, 1'b0);
        wait_done();
        check(got.size() == 35, "R6 word count", got.size(), 35);
        check(got[0] == 16'h6080, "R2 start", int'(got[0]), 'h6080);
        check(got[1] == 16'h6480, "R3 select DAC1", int'(got[1]), 'h6480);
        check(got[10] == 16'hC480, "R4 value msb clock high", int'(got[10]), 'hC480);
        check(got[11] == 16'h8480, "R4 value msb clock low", int'(got[11]), 'h8480);
        check(got[18] == 16'h4480, "R5 value bit3 clock high", int'(got[18]), 'h4480);
        check(got[19] == 16'h0480, "R5 value bit3 clock low", int'(got[19]), 'h0480);
        check(got[34] == 16'h4080, "R6 end word", int'(got[34]), 'h4080);

        // DAC two, speed flag, back-pressure, stray request and flag changes while busy
        stall_on = 1'b1;
        start_load(2'b10, 8'h00, 1'b1, 1'b0);
        repeat (4) @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_sel   = 2'b11;
        req_value = 8'hA5;
        req_speed = 1'b0;
        req_power = 1'b1;
        repeat (20) @(posedge clk);
        #1 req_valid = 1'b0;
        wait_done();
        check(got.size() == 35, "R8 ignored request word count", got.size(), 35);
        check(got[1] == 16'h6880, "R3 select DAC2", int'(got[1]), 'h6880);
        check(got[4] == 16'hC880, "R11 latched speed", int'(got[4]), 'hC880);
        check(got[6] == 16'h4880, "R11 latched power", int'(got[6]), 'h4880);

        // both DACs, full-scale value, power flag
        start_load(2'b11, 8'hFF, 1'b0, 1'b1);
        wait_done();
        check(got[1] == 16'h6C80, "R3 select both", int'(got[1]), 'h6C80);
        check(got[6] == 16'hCC80, "R5 power bit", int'(got[6]), 'hCC80);
        check(got[26] == 16'h4C80, "R5 zero tail", int'(got[26]), 'h4C80);

        // reset in the middle of a load
        stall_on = 1'b0;
        start_load(2'b01, 8'h5A, 1'b1, 1'b1);
        repeat (30) @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0,
              "R10 mid-load reset", int'({req_ready, cmd_valid, done}), 'b100);

        // back-to-back loads: second request right after done
        start_load(2'b01, 8'h81, 1'b0, 1'b0);
        wait_done();
        start_load(2'b10, 8'h7E, 1'b0, 1'b0);
        wait_done();
        check(got.size() == 35, "R6 second back-to-back count", got.size(), 35);
        check(got[34] == 16'h4080, "R6 second back-to-back end", int'(got[34]), 'h4080);

        repeat (5) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        while (cycles < WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule